// File: doc/BRIEF.md
# DMA Channel Command Controller

This block runs one DMA channel. Software loads a source pointer, a destination pointer, a unit count, two pointer-step flags and a transfer mode. It then sets a hardware enable bit and issues two-bit commands. The channel moves data one word at a time over a simple memory port. Each unit is a single read from the source pointer followed by a single write of that data to the destination pointer, and the unit count drops by one after every completed write.

Work reaches the channel in one of two ways. An external requester can raise a request line. In whole-transfer mode, software can also start the channel directly with a command. Pause stops the channel at the next unit boundary, and a pending request is remembered while paused. Cancel stops the channel at once and clears the enable bit. When the count runs out, the enable bit clears and a done flag rises. Block mode moves a group of four units per request, and it refuses to begin a group when either pointer is not 16-byte aligned.

Top module: `dma_cmd_chan`

## Requirements
- R1: The command register takes the code written on `cmd_wdata`, with 00 = none, 01 = start, 10 = pause and 11 = cancel. `cmd_o` shows that code in the cycle after the write and returns to 00 one cycle later unless a new code is written.
- R2: After reset, `en_o`, `cmd_o`, `done_o`, `err_o`, `paused_o`, `xack` and `mem_req` are all 0.
- R3: While `en_o` is 0 the channel starts no unit, even when a start command is issued.
- R4: The mode field uses 00 = per-request unit, 01 = block, 10 = whole and 11 = per-request unit. In whole mode, a start command (or one request) with the enable bit set runs units until the count is zero. In the other modes a start command begins no transfer.
- R5: In per-request mode, each rising edge of `xreq` seen while enabled causes exactly one unit. `xack` is high during every read cycle and every write cycle of the unit.
- R6: Pause (10) lets the current unit finish and then starts no further unit. Rising edges of `xreq` seen while paused are kept. A start command (01) clears the pause and lets kept work proceed.
- R7: Cancel (11) returns the channel to idle in the next cycle. It drops an unfinished unit without counting it, clears the enable bit and discards kept requests.
- R8: The count drops by one per completed write. When it reaches zero, the enable bit clears and `done_o` is set.
- R9: A unit reads at the source pointer, then writes the data read to the destination pointer. Each pointer advances by 4 after the unit when its step flag is 1 and stays fixed when it is 0.
- R10: In block mode, each accepted request moves four units. A group starts only when bits [3:0] of both pointers are zero. Otherwise the request is dropped, `err_o` is set and `en_o` is left unchanged.
- R11: A configuration write takes effect only while the enable bit is 0 and the channel is idle. It clears `done_o` and `err_o`.
- R12: When a cancel is decoded in the same cycle as the last write completes, the write stands: the count reaches zero, `done_o` is set and `en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_src | input | AW | Source pointer to load |
| cfg_dst | input | AW | Destination pointer to load |
| cfg_cnt | input | CW | Unit count to load |
| cfg_src_inc | input | 1 | Source pointer steps when 1 |
| cfg_dst_inc | input | 1 | Destination pointer steps when 1 |
| cfg_mode | input | 2 | Transfer mode |
| en_wr | input | 1 | Enable bit write strobe |
| en_wdata | input | 1 | Enable bit value |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 2 | Command code |
| xreq | input | 1 | External transfer request |
| xack | output | 1 | Unit in progress acknowledge |
| mem_req | output | 1 | Memory cycle valid |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Memory cycle completes this clock |
| en_o | output | 1 | Enable bit |
| cmd_o | output | 2 | Command register |
| cnt_o | output | CW | Remaining unit count |
| paused_o | output | 1 | Channel is paused |
| done_o | output | 1 | Count reached zero |
| err_o | output | 1 | Block start refused for alignment |

## Verification
A cancel and the final write of a transfer can meet in the same cycle. To provoke this, the bench holds `mem_ready` low once the last unit has reached its write cycle and writes a cancel. It then raises `mem_ready` in exactly the cycle in which the cancel is decoded. The result counts as correct when the write appears once on the bus, the count reads zero, `done_o` is set and the enable bit is clear, which shows that cancel only drops work that has not finished.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'b00,
        CMD_START  = 2'b01,
        CMD_PAUSE  = 2'b10,
        CMD_CANCEL = 2'b11
    } dma_cmd_e;

    typedef enum logic [1:0] {
        MODE_UNIT     = 2'b00,
        MODE_BLOCK    = 2'b01,
        MODE_WHOLE    = 2'b10,
        MODE_UNIT_ALT = 2'b11
    } dma_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RD   = 2'b01,
        ST_WR   = 2'b10
    } dma_st_e;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
    import dma_cmd_pkg::*;
(
    input  dma_cmd_e  cmd_i,
    input  logic      en_i,
    input  dma_mode_e mode_i,
    output logic      start_o,
    output logic      run_o,
    output logic      pause_o,
    output logic      cancel_o
);

    always_comb begin
        start_o  = 1'b0;
        pause_o  = 1'b0;
        cancel_o = 1'b0;
        case (cmd_i)
            CMD_START:  start_o  = 1'b1;
            CMD_PAUSE:  pause_o  = 1'b1;
            CMD_CANCEL: cancel_o = 1'b1;
            default:    ;
        endcase
        // a software start only launches a run in whole mode with enable set
        run_o = start_o && en_i && (mode_i == MODE_WHOLE);
    end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW         = 32,
    parameter int STEP       = 4,
    parameter int ALIGN_BITS = 4
) (
    input  logic [AW-1:0] addr_i,
    input  logic          inc_i,
    output logic [AW-1:0] nxt_o,
    output logic          aligned_o
);

    assign nxt_o     = inc_i ? addr_i + AW'(STEP) : addr_i;
    assign aligned_o = (addr_i[ALIGN_BITS-1:0] == '0);

endmodule

// File: rtl/dma_cmd_chan.sv
module dma_cmd_chan
    import dma_cmd_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int CW         = 16,
    parameter int BLK_UNITS  = 4,
    parameter int ALIGN_BITS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_cnt,
    input  logic          cfg_src_inc,
    input  logic          cfg_dst_inc,
    input  logic [1:0]    cfg_mode,
    input  logic          en_wr,
    input  logic          en_wdata,
    input  logic          cmd_wr,
    input  logic [1:0]    cmd_wdata,
    input  logic          xreq,
    output logic          xack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          en_o,
    output logic [1:0]    cmd_o,
    output logic [CW-1:0] cnt_o,
    output logic          paused_o,
    output logic          done_o,
    output logic          err_o
);

    localparam int WORD_BYTES = DW / 8;
    localparam int BLW        = (BLK_UNITS > 1) ? $clog2(BLK_UNITS) : 1;
    localparam int NPTR       = 2;   // index 0 = source, 1 = destination

    typedef struct packed {
        dma_st_e                   st;
        logic                      en;
        logic                      paused;
        logic                      run;
        logic                      pend;
        logic                      done;
        logic                      err;
        logic                      xreq_prev;
        dma_cmd_e                  cmd;
        dma_mode_e                 mode;
        logic [NPTR-1:0]           inc;
        logic [NPTR-1:0][AW-1:0]   ptr;
        logic [CW-1:0]             cnt;
        logic [BLW-1:0]            blk_left;
        logic [DW-1:0]             data;
    } chan_t;

    chan_t ch_d, ch_q;

    logic dec_start, dec_run, dec_pause, dec_cancel;
    logic req_edge, owed;
    logic [NPTR-1:0][AW-1:0] ptr_nxt;
    logic [NPTR-1:0]         ptr_ok;

    dma_cmd_decode u_dec (
        .cmd_i    (ch_q.cmd),
        .en_i     (ch_q.en),
        .mode_i   (ch_q.mode),
        .start_o  (dec_start),
        .run_o    (dec_run),
        .pause_o  (dec_pause),
        .cancel_o (dec_cancel)
    );

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dma_addr_step #(
            .AW         (AW),
            .STEP       (WORD_BYTES),
            .ALIGN_BITS (ALIGN_BITS)
        ) u_step (
            .addr_i    (ch_q.ptr[g]),
            .inc_i     (ch_q.inc[g]),
            .nxt_o     (ptr_nxt[g]),
            .aligned_o (ptr_ok[g])
        );
    end

    assign req_edge = xreq && !ch_q.xreq_prev && ch_q.en;
    assign owed     = ch_q.run || ch_q.pend || (ch_q.blk_left != '0);

    always_comb begin
        ch_d           = ch_q;
        ch_d.cmd       = cmd_wr ? dma_cmd_e'(cmd_wdata) : CMD_NONE;
        ch_d.xreq_prev = xreq;

        // software side: configuration, enable, command effects
        if (cfg_wr && !ch_q.en && ch_q.st == ST_IDLE) begin
            ch_d.ptr[0]   = cfg_src;
            ch_d.ptr[1]   = cfg_dst;
            ch_d.inc      = {cfg_dst_inc, cfg_src_inc};
            ch_d.cnt      = cfg_cnt;
            ch_d.mode     = dma_mode_e'(cfg_mode);
            ch_d.done     = 1'b0;
            ch_d.err      = 1'b0;
            ch_d.pend     = 1'b0;
            ch_d.run      = 1'b0;
            ch_d.paused   = 1'b0;
            ch_d.blk_left = '0;
        end
        if (en_wr)     ch_d.en     = en_wdata;
        if (req_edge)  ch_d.pend   = 1'b1;
        if (dec_pause) ch_d.paused = 1'b1;
        if (dec_start) ch_d.paused = 1'b0;
        if (dec_run)   ch_d.run    = 1'b1;

        // unit sequencer
        case (ch_q.st)
            ST_IDLE: begin
                if (ch_q.en && !ch_q.paused && ch_q.cnt != '0 && owed) begin
                    if (ch_q.mode == MODE_BLOCK && ch_q.blk_left == '0 &&
                        !(ptr_ok[0] && ptr_ok[1])) begin
                        ch_d.err  = 1'b1;
                        ch_d.pend = req_edge;
                    end else begin
                        ch_d.st = ST_RD;
                        if (ch_q.blk_left != '0) begin
                            ch_d.blk_left = ch_q.blk_left - 1'b1;
                        end else if (!ch_q.run) begin
                            ch_d.pend = req_edge;
                            if (ch_q.mode == MODE_WHOLE) ch_d.run = 1'b1;
                            if (ch_q.mode == MODE_BLOCK) ch_d.blk_left = BLW'(BLK_UNITS - 1);
                        end
                    end
                end
            end
            ST_RD: begin
                if (mem_ready) begin
                    ch_d.data = mem_rdata;
                    ch_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ready) begin
                    ch_d.cnt = ch_q.cnt - 1'b1;
                    ch_d.ptr = ptr_nxt;
                    ch_d.st  = ST_IDLE;
                    if (ch_q.cnt == CW'(1)) begin
                        ch_d.en       = 1'b0;
                        ch_d.done     = 1'b1;
                        ch_d.run      = 1'b0;
                        ch_d.pend     = 1'b0;
                        ch_d.blk_left = '0;
                    end
                end
            end
            default: ch_d.st = ST_IDLE;
        endcase

        // cancel drops unfinished work; a write completing now still counts
        if (dec_cancel) begin
            ch_d.st       = ST_IDLE;
            ch_d.en       = 1'b0;
            ch_d.run      = 1'b0;
            ch_d.pend     = 1'b0;
            ch_d.paused   = 1'b0;
            ch_d.blk_left = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign mem_req   = (ch_q.st != ST_IDLE);
    assign mem_we    = (ch_q.st == ST_WR);
    assign mem_addr  = (ch_q.st == ST_WR) ? ch_q.ptr[1] : ch_q.ptr[0];
    assign mem_wdata = ch_q.data;
    assign xack      = mem_req;
    assign en_o      = ch_q.en;
    assign cmd_o     = ch_q.cmd;
    assign cnt_o     = ch_q.cnt;
    assign paused_o  = ch_q.paused;
    assign done_o    = ch_q.done;
    assign err_o     = ch_q.err;

    AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> (cmd_o == 2'b00)); // R1

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !mem_req) |=> !mem_req); // R3

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (paused_o && !mem_req) |=> !mem_req); // R6

    AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_q.cmd == CMD_CANCEL) |=> (!en_o && !mem_req)); // R7

    AST_TC_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_ready && cnt_o == CW'(1)) |=> (!en_o && done_o && cnt_o == '0)); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (cnt_o != '0)); // R8

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready && ch_q.cmd != CMD_CANCEL)
        |=> (xack && mem_we && mem_wdata == $past(mem_rdata))); // R9

    AST_ALIGN_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !mem_req); // R10

endmodule

// File: tb/dma_cmd_chan_test.sv
`timescale 1ns/1ps
module dma_cmd_chan_test;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [AW-1:0] cfg_src = '0;
    logic [AW-1:0] cfg_dst = '0;
    logic [CW-1:0] cfg_cnt = '0;
    logic          cfg_src_inc = 1'b0;
    logic          cfg_dst_inc = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic          en_wr = 1'b0;
    logic          en_wdata = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [1:0]    cmd_wdata = 2'b00;
    logic          xreq = 1'b0;
    logic          xack;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_ready = 1'b1;
    logic          en_o;
    logic [1:0]    cmd_o;
    logic [CW-1:0] cnt_o;
    logic          paused_o;
    logic          done_o;
    logic          err_o;

    int n_chk = 0;
    int n_bad = 0;
    int wr_n = 0;
    int rd_n = 0;
    int ack_miss = 0;
    logic [AW-1:0] last_wa = '0;
    logic [DW-1:0] last_wd = '0;

    always #2 clk = ~clk;

    assign mem_rdata = mem_addr ^ 32'h5A00_0000;

    dma_cmd_chan uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
        .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc), .cfg_mode(cfg_mode),
        .en_wr(en_wr), .en_wdata(en_wdata), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .xreq(xreq), .xack(xack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .en_o(en_o), .cmd_o(cmd_o), .cnt_o(cnt_o), .paused_o(paused_o),
        .done_o(done_o), .err_o(err_o)
    );

    // bus monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            if (mem_we) begin
                wr_n    = wr_n + 1;
                last_wa = mem_addr;
                last_wd = mem_wdata;
            end else begin
                rd_n = rd_n + 1;
            end
            if (!xack) ack_miss = ack_miss + 1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic [31:0] s, input logic [31:0] d, input int c,
                       input logic si, input logic di, input logic [1:0] m);
        cfg_src = s; cfg_dst = d; cfg_cnt = CW'(c);
        cfg_src_inc = si; cfg_dst_inc = di; cfg_mode = m;
        cfg_wr = 1'b1;
        tick(1);
        cfg_wr = 1'b0;
    endtask

    task automatic set_en(input logic v);
        en_wr = 1'b1; en_wdata = v;
        tick(1);
        en_wr = 1'b0;
    endtask

    task automatic cmd(input logic [1:0] c);
        cmd_wr = 1'b1; cmd_wdata = c;
        tick(1);
        cmd_wr = 1'b0;
    endtask

    task automatic pulse_req();
        xreq = 1'b1;
        tick(1);
        xreq = 1'b0;
        tick(1);
    endtask

    task automatic wait_done(input int max);
        for (int i = 0; i < max && !done_o; i++) tick(1);
    endtask

    task automatic t_reset();
        chk("R2", "en_o", en_o, 0);
        chk("R2", "cmd_o", cmd_o, 0);
        chk("R2", "done_o", done_o, 0);
        chk("R2", "err_o", err_o, 0);
        chk("R2", "paused_o", paused_o, 0);
        chk("R2", "xack", xack, 0);
        chk("R2", "mem_req", mem_req, 0);
    endtask

    task automatic t_self_clear();
        cmd(2'b10);
        chk("R1", "cmd_o after write", cmd_o, 2);
        tick(1);
        chk("R1", "cmd_o one cycle later", cmd_o, 0);
    endtask

    task automatic t_disabled();
        int base;
        base = wr_n;
        cfg(32'h40, 32'h80, 4, 1, 1, 2'b10);
        cmd(2'b01);
        tick(15);
        chk("R3", "writes while disabled", wr_n - base, 0);
        chk("R3", "count kept", cnt_o, 4);
        chk("R3", "xack idle", xack, 0);
    endtask

    task automatic t_whole();
        int base;
        cfg(32'h40, 32'h80, 5, 1, 1, 2'b10);
        set_en(1'b1);
        base = wr_n;
        cmd(2'b01);
        wait_done(200);
        chk("R4", "whole mode writes", wr_n - base, 5);
        chk("R8", "done_o", done_o, 1);
        chk("R8", "en_o cleared", en_o, 0);
        chk("R8", "cnt_o", cnt_o, 0);
        chk("R9", "last write addr", last_wa, 32'h90);
        chk("R9", "last write data", last_wd, 32'h5A00_0050);
    endtask

    task automatic t_unit();
        int base;
        cfg(32'h300, 32'h400, 3, 0, 1, 2'b00);
        chk("R11", "done cleared by config", done_o, 0);
        set_en(1'b1);
        base = wr_n;
        cmd(2'b01);
        tick(10);
        chk("R4", "start ignored in unit mode", wr_n - base, 0);
        pulse_req();
        tick(10);
        chk("R5", "one unit per request", wr_n - base, 1);
        chk("R5", "cnt_o after one", cnt_o, 2);
        pulse_req();
        tick(8);
        pulse_req();
        wait_done(50);
        chk("R5", "three requests", wr_n - base, 3);
        chk("R5", "xack over bus cycles", ack_miss, 0);
        chk("R9", "dest stepped", last_wa, 32'h408);
        chk("R9", "source fixed", last_wd, 32'h5A00_0300);
        chk("R8", "en_o after last", en_o, 0);
    endtask

    task automatic t_pause();
        int base, rbase, w1, r1;
        cfg(32'h700, 32'h800, 6, 1, 1, 2'b10);
        set_en(1'b1);
        base = wr_n; rbase = rd_n;
        cmd(2'b01);
        for (int i = 0; i < 100 && (wr_n - base) < 2; i++) tick(1);
        cmd(2'b10);
        tick(8);
        w1 = wr_n - base; r1 = rd_n - rbase;
        chk("R6", "paused_o", paused_o, 1);
        tick(10);
        chk("R6", "no progress while paused", wr_n - base, w1);
        chk("R6", "stopped at unit boundary", r1, w1);
        chk("R6", "count matches", cnt_o, 6 - w1);
        cmd(2'b01);
        wait_done(200);
        chk("R6", "resume completes", wr_n - base, 6);
        // request kept while paused
        cfg(32'h500, 32'h600, 2, 1, 1, 2'b00);
        set_en(1'b1);
        base = wr_n;
        cmd(2'b10);
        tick(2);
        pulse_req();
        tick(10);
        chk("R6", "no unit while paused", wr_n - base, 0);
        cmd(2'b01);
        tick(10);
        chk("R6", "kept request serviced", wr_n - base, 1);
        chk("R6", "cnt_o after resume", cnt_o, 1);
        cmd(2'b11);
        tick(2);
        chk("R7", "cancel clears enable", en_o, 0);
    endtask

    task automatic t_cancel();
        int base;
        cfg(32'h100, 32'h200, 8, 1, 1, 2'b10);
        set_en(1'b1);
        mem_ready = 1'b0;
        base = wr_n;
        cmd(2'b01);
        for (int i = 0; i < 50 && !mem_req; i++) tick(1);
        cmd(2'b11);
        tick(1);
        chk("R7", "en_o", en_o, 0);
        chk("R7", "xack", xack, 0);
        chk("R7", "mem_req", mem_req, 0);
        chk("R7", "unfinished unit not counted", cnt_o, 8);
        mem_ready = 1'b1;
        tick(10);
        chk("R7", "no bus activity", wr_n - base, 0);
    endtask

    task automatic t_block();
        int base;
        cfg(32'h1000, 32'h2000, 8, 1, 1, 2'b01);
        set_en(1'b1);
        base = wr_n;
        pulse_req();
        tick(40);
        chk("R10", "group of four", wr_n - base, 4);
        chk("R10", "cnt_o after group", cnt_o, 4);
        chk("R10", "group end addr", last_wa, 32'h200C);
        pulse_req();
        wait_done(60);
        chk("R10", "second group", wr_n - base, 8);
        chk("R10", "done", done_o, 1);
        // misaligned source
        cfg(32'h1004, 32'h2000, 4, 1, 1, 2'b01);
        set_en(1'b1);
        base = wr_n;
        pulse_req();
        tick(10);
        chk("R10", "err_o", err_o, 1);
        chk("R10", "refused", wr_n - base, 0);
        chk("R10", "en_o kept", en_o, 1);
    endtask

    task automatic t_cfg_gate();
        cfg(32'h0, 32'h0, 9, 1, 1, 2'b00);
        chk("R11", "config ignored while enabled", cnt_o, 4);
        chk("R11", "err kept", err_o, 1);
        set_en(1'b0);
        cfg(32'h0, 32'h0, 9, 1, 1, 2'b00);
        chk("R11", "config taken", cnt_o, 9);
        chk("R11", "err cleared", err_o, 0);
    endtask

    task automatic t_collide();
        int base;
        cfg(32'hA00, 32'hB00, 1, 1, 1, 2'b10);
        set_en(1'b1);
        mem_ready = 1'b0;
        base = wr_n;
        cmd(2'b01);
        for (int i = 0; i < 50 && !mem_req; i++) tick(1);
        mem_ready = 1'b1;
        tick(1);
        mem_ready = 1'b0;
        chk("R12", "in write cycle", mem_we, 1);
        cmd_wr = 1'b1; cmd_wdata = 2'b11;
        tick(1);
        cmd_wr = 1'b0;
        mem_ready = 1'b1;
        tick(1);
        chk("R12", "write stands", wr_n - base, 1);
        chk("R12", "cnt_o", cnt_o, 0);
        chk("R12", "done_o", done_o, 1);
        chk("R12", "en_o", en_o, 0);
        chk("R12", "idle", mem_req, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick(1);
        t_reset();
        t_self_clear();
        t_disabled();
        t_whole();
        t_unit();
        t_pause();
        t_cancel();
        t_block();
        t_cfg_gate();
        t_collide();
        tick(2);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule